// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block is a calendar clock that a processor reads and writes as eight bytes on a simple synchronous parallel bus. The bytes sit at the eight highest addresses of the bus address space. They hold century, seconds, minutes, hour, day of week, date, month and year, each in packed BCD, with the tens digit in the upper nibble and the units digit in bits 3:0. A one-cycle pulse on `tick` arrives once per second. Each pulse advances a set of running counters, with carries from seconds up to century and with month lengths that follow the leap-year rule.

Software sees a copy of the counters, not the counters themselves. A hold-for-write bit stops the copy so that new time values can be written. Clearing that bit loads the written values into the counters. A hold-for-read bit freezes the copy so that all eight bytes form one coherent snapshot, while the counters keep running. The clock bytes also carry control bits: an oscillator stop bit and a square-wave test enable. They carry a read-only low-battery flag that comes from an input pin. Bits with no clock function are plain storage and keep whatever software last wrote.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the bytes read, by offset 0..7: century 00, seconds 00, minutes 00, hour 00, day 01, date 01, month 01, year 00. Every control and storage bit is 0, and `sqw` is low.
- R2: Byte offset = `addr[2:0]` when `addr[ADDR_W-1:3]` is all ones (0 century, 1 seconds, 2 minutes, 3 hour, 4 day, 5 date, 6 month, 7 year). Any other address reads 8'h00 and writes to it change nothing.
- R3: A read occurs when `ce_n`=0, `oe_n`=0 and `we_n`=1, and it raises `dout_en`. A write occurs on a clock edge with `ce_n`=0 and `we_n`=0. When no read is under way, `dout_en`=0 and `dout`=8'h00, and a write with `ce_n`=1 is ignored.
- R4: Each `tick` advances seconds 00..59 → minutes 00..59 → hour 00..23, all in BCD. The visible bytes show the new time no more than two clock cycles after the pulse.
- R5: Date wraps to 01 after the last day of the month: 31 days, or 30 for months 04, 06, 09 and 11. February has 28 days, or 29 when the year value is divisible by four. The month then advances, wrapping from 12 to 01.
- R6: Day of week (day byte bits 2:0) advances with the date and wraps from 7 to 1. Year wraps from 99 to 00 and increments the century, which wraps from 39 to 00.
- R7: While seconds bit 7 (oscillator stop) is 1, ticks do not advance the time.
- R8: While century bit 7 (hold-for-write) is 1, the visible time stays unchanged despite ticks. The write that clears the bit loads all visible time fields into the counters, and ticks that arrived during the hold are discarded.
- R9: While century bit 6 (hold-for-read) is 1, the visible bytes stay frozen while the counters keep running. Once the bit is cleared, reads show the advanced time.
- R10: Storage bits keep their written values across ticks: minutes bit 7, hour bits 7:6, date bits 7:6, month bits 7:5 and day bits 5:3.
- R11: Day bit 7 always reads as the `batt_low` input, whatever was written to it.
- R12: With day bit 6 (test enable) set and the oscillator running, `sqw` toggles on every tick. With the test enable clear, `sqw` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 8'h00 when not reading |
| dout_en | output | 1 | High while read data is driven |
| batt_low | input | 1 | Low-battery status shown in day bit 7 |
| sqw | output | 1 | Square-wave test output |

## Verification
The bench targets the calendar edges: 23:59:59 on 28 February of leap and non-leap years, 30 April, 31 December of year 99 with century 39, and day 7. A wrong month-length or leap rule shows up there as a skipped or extra date, and a broken carry as a stuck higher field. Storage bits are written with distinct patterns and then ticked past minute and hour boundaries. A copy path that overwrote whole bytes would clear those bits. The hold bits are checked by ticking during the hold. A design that leaked counter values into a frozen snapshot would show a changed byte. A design that kept ticks received during a write hold would come back one or more seconds ahead.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the clock register bank.
// Assumes byte-wide registers laid out at eight consecutive offsets.
package rtc_pkg;

    localparam int NREG = 8;

    typedef logic [7:0] byte_t;
    typedef logic [NREG-1:0][7:0] bank_t;

    localparam logic [2:0] OFS_CENT  = 3'd0;
    localparam logic [2:0] OFS_SEC   = 3'd1;
    localparam logic [2:0] OFS_MIN   = 3'd2;
    localparam logic [2:0] OFS_HOUR  = 3'd3;
    localparam logic [2:0] OFS_DAY   = 3'd4;
    localparam logic [2:0] OFS_DATE  = 3'd5;
    localparam logic [2:0] OFS_MONTH = 3'd6;
    localparam logic [2:0] OFS_YEAR  = 3'd7;

    // Bits of each byte that belong to the running time field.
    function automatic byte_t field_mask(input logic [2:0] ofs);
        case (ofs)
            OFS_CENT:  return 8'h3F;
            OFS_SEC:   return 8'h7F;
            OFS_MIN:   return 8'h7F;
            OFS_HOUR:  return 8'h3F;
            OFS_DAY:   return 8'h07;
            OFS_DATE:  return 8'h3F;
            OFS_MONTH: return 8'h1F;
            default:   return 8'hFF;
        endcase
    endfunction

    // Reset contents of the time fields.
    function automatic bank_t reset_bank();
        bank_t b;
        b = '0;
        b[OFS_DAY]   = 8'h01;
        b[OFS_DATE]  = 8'h01;
        b[OFS_MONTH] = 8'h01;
        return b;
    endfunction

    // Increment a BCD byte within [lo, hi]; bit 8 flags a wrap to lo.
    function automatic logic [8:0] bcd_step(input byte_t v, input byte_t lo, input byte_t hi);
        logic [3:0] t;
        logic [3:0] u;
        t = v[7:4];
        u = v[3:0];
        if (v >= hi) return {1'b1, lo};
        if (u >= 4'd9) begin
            t = t + 4'd1;
            u = 4'd0;
        end else begin
            u = u + 4'd1;
        end
        return {1'b0, t, u};
    endfunction

    // Last date of a month in BCD; leap when the year value is a multiple of four.
    function automatic byte_t month_len(input byte_t mon, input byte_t yr);
        logic [6:0] ybin;
        ybin = 7'({3'b000, yr[7:4]} * 7'd10) + {3'b000, yr[3:0]};
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
// Decodes the parallel bus strobes and address into read, write and byte select.
// Assumes the eight clock bytes occupy the highest addresses; ADDR_W > 3.
module rtc_bus_decode #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              rd_en,
    output logic              wr_en,
    output logic              hit,
    output logic [2:0]        ofs
);
    localparam int UPPER_W = ADDR_W - 3;

    // Strobe qualification and range check.
    always_comb begin
        rd_en = !ce_n && !oe_n && we_n;
        wr_en = !ce_n && !we_n;
        hit   = (addr[ADDR_W-1:3] == {UPPER_W{1'b1}});
        ofs   = addr[2:0];
    end
endmodule

// File: rtl/rtc_calendar.sv
// Running BCD counters for seconds through century.
// Assumes load and step are single-cycle; load has priority and masks out non-time bits.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  load,
    input  bank_t load_val,
    output bank_t cnt
);
    bank_t      nxt;
    bank_t      masked;
    logic [8:0] s_sec, s_min, s_hour, s_day, s_date, s_mon, s_year, s_cent;

    // Strip control and storage bits from the load image.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            masked[i] = load_val[i] & field_mask(3'(i));
        end
    end

    // Carry chain from seconds to century.
    always_comb begin
        nxt    = cnt;
        s_sec  = bcd_step(cnt[OFS_SEC], 8'h00, 8'h59);
        s_min  = bcd_step(cnt[OFS_MIN], 8'h00, 8'h59);
        s_hour = bcd_step(cnt[OFS_HOUR], 8'h00, 8'h23);
        s_day  = bcd_step(cnt[OFS_DAY], 8'h01, 8'h07);
        s_date = bcd_step(cnt[OFS_DATE], 8'h01, month_len(cnt[OFS_MONTH], cnt[OFS_YEAR]));
        s_mon  = bcd_step(cnt[OFS_MONTH], 8'h01, 8'h12);
        s_year = bcd_step(cnt[OFS_YEAR], 8'h00, 8'h99);
        s_cent = bcd_step(cnt[OFS_CENT], 8'h00, 8'h39);
        nxt[OFS_SEC] = s_sec[7:0];
        if (s_sec[8]) begin
            nxt[OFS_MIN] = s_min[7:0];
            if (s_min[8]) begin
                nxt[OFS_HOUR] = s_hour[7:0];
                if (s_hour[8]) begin
                    nxt[OFS_DAY]  = s_day[7:0];
                    nxt[OFS_DATE] = s_date[7:0];
                    if (s_date[8]) begin
                        nxt[OFS_MONTH] = s_mon[7:0];
                        if (s_mon[8]) begin
                            nxt[OFS_YEAR] = s_year[7:0];
                            if (s_year[8]) begin
                                nxt[OFS_CENT] = s_cent[7:0];
                            end
                        end
                    end
                end
            end
        end
    end

    // Counter register: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= reset_bank();
        end else if (load) begin
            cnt <= masked;
        end else if (step) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/rtc_sqw.sv
// Square-wave test output that toggles per tick while enabled.
// Assumes tick is a single-cycle pulse; output parks low when disabled.
module rtc_sqw (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    output logic sqw
);
    // Toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sqw <= 1'b0;
        end else if (tick) begin
            sqw <= ~sqw;
        end
    end
endmodule

// File: rtl/rtc_regbank.sv
// Clock register bank: visible bytes, hold bits and read mux over the running counters.
// Assumes a synchronous bus; reads are combinational from the visible copy, writes land on the clock edge.
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    input  logic              batt_low,
    output logic              sqw
);
    logic       rd_en, wr_en, hit;
    logic [2:0] ofs;
    logic       wr_hit;
    bank_t      vis;
    bank_t      vis_nxt;
    bank_t      cnt_bank;
    logic       hold_w, hold_r, osc_stop, ft_en;
    logic       cnt_load;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .hit   (hit),
        .ofs   (ofs)
    );

    // Control bits taken from the visible bytes.
    always_comb begin
        hold_w   = vis[OFS_CENT][7];
        hold_r   = vis[OFS_CENT][6];
        osc_stop = vis[OFS_SEC][7];
        ft_en    = vis[OFS_DAY][6];
        wr_hit   = wr_en && hit;
    end

    // Next visible image: bus write wins, otherwise track the counters when no hold is set.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            if (wr_hit && (ofs == 3'(i))) begin
                vis_nxt[i] = din;
            end else if (!hold_w && !hold_r) begin
                vis_nxt[i] = (vis[i] & ~field_mask(3'(i))) | (cnt_bank[i] & field_mask(3'(i)));
            end else begin
                vis_nxt[i] = vis[i];
            end
        end
        cnt_load = hold_w && !vis_nxt[OFS_CENT][7];
    end

    // Visible register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis <= reset_bank();
        end else begin
            vis <= vis_nxt;
        end
    end

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick && !osc_stop),
        .load     (cnt_load),
        .load_val (vis_nxt),
        .cnt      (cnt_bank)
    );

    rtc_sqw u_sqw (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .enable (ft_en && !osc_stop),
        .sqw    (sqw)
    );

    // Read mux with battery flag substituted into the day byte.
    always_comb begin
        dout_en = rd_en;
        dout    = 8'h00;
        if (rd_en && hit) begin
            dout = (ofs == OFS_DAY) ? {batt_low, vis[OFS_DAY][6:0]} : vis[ofs];
        end
    end
endmodule

// File: rtl/rtc_regbank_chk.sv
// Property checker for the clock register bank, attached by bind.
// Assumes it observes the top's ports and its hold, load and counter signals.
module rtc_regbank_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              batt_low,
    input logic              sqw,
    input logic              hold_w,
    input logic              hold_r,
    input logic              osc_stop,
    input logic              ft_en,
    input logic              cnt_load,
    input logic              wr_hit,
    input bank_t             vis,
    input bank_t             cnt_bank
);
    localparam logic [ADDR_W-1:0] DAY_ADDR = {{(ADDR_W-3){1'b1}}, OFS_DAY};

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

    p_no_read_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_en);

    p_tick_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !osc_stop && !cnt_load) |=> !$stable(cnt_bank));

    p_stop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !cnt_load) |=> $stable(cnt_bank));

    p_write_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_w && !wr_hit) |=> $stable(vis));

    p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !hold_w);

    p_read_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_r && !wr_hit) |=> $stable(vis));

    p_batt_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && addr == DAY_ADDR) |-> (dout[7] == batt_low));

    p_sqw_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ft_en |=> !sqw);

    p_sqw_toggle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ft_en && !osc_stop) |=> (sqw != $past(sqw)));
endmodule

bind rtc_regbank rtc_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .we_n     (we_n),
    .addr     (addr),
    .dout     (dout),
    .dout_en  (dout_en),
    .batt_low (batt_low),
    .sqw      (sqw),
    .hold_w   (hold_w),
    .hold_r   (hold_r),
    .osc_stop (osc_stop),
    .ft_en    (ft_en),
    .cnt_load (cnt_load),
    .wr_hit   (wr_hit),
    .vis      (vis),
    .cnt_bank (cnt_bank)
);

// File: tb/rtc_regbank_test.sv
`timescale 1ns/1ps
module rtc_regbank_test;
    localparam int ADDR_W = 11;
    localparam logic [ADDR_W-1:0] BASE = {{(ADDR_W-3){1'b1}}, 3'b000};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_en;
    logic              batt_low = 1'b0;
    logic              sqw;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Model state in binary, plus expected non-time bits per byte.
    int mc, my, mmo, md, mdw, mh, mmi, ms;
    logic [7:0] e_hi [8];
    bit e_stop, e_ft, e_sqw;

    rtc_regbank #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .batt_low(batt_low), .sqw(sqw)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mmi++;
            if (mmi == 60) begin
                mmi = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    md++;
                    if (md > dim(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my++;
                            if (my == 100) begin
                                my = 0;
                                mc = (mc == 39) ? 0 : mc + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    function automatic logic [7:0] field(input int i);
        case (i)
            0: return bcd(mc);
            1: return bcd(ms);
            2: return bcd(mmi);
            3: return bcd(mh);
            4: return bcd(mdw);
            5: return bcd(md);
            6: return bcd(mmo);
            default: return bcd(my);
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input int i);
        logic [7:0] v;
        v = e_hi[i] | field(i);
        if (i == 4) v[7] = batt_low;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        v = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        logic en;
        for (int i = 0; i < 8; i++) begin
            bus_read(BASE + ADDR_W'(i), v, en);
            chk(tag, v, exp_byte(i));
        end
    endtask

    // Frozen check: compare to a captured image.
    task automatic check_image(input string tag, input logic [7:0] img [8]);
        logic [7:0] v;
        logic en;
        for (int i = 0; i < 8; i++) begin
            bus_read(BASE + ADDR_W'(i), v, en);
            chk(tag, v, img[i]);
        end
    endtask

    task automatic do_tick(input bit advance_model);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (!e_stop && advance_model) model_step();
        if (e_ft && !e_stop) e_sqw = ~e_sqw;
    endtask

    task automatic set_time(input int c, input int y, input int mo, input int d,
                            input int dw, input int h, input int mi, input int s);
        bus_write(BASE + 0, 8'h80 | bcd(c));
        bus_write(BASE + 7, e_hi[7] | bcd(y));
        bus_write(BASE + 6, e_hi[6] | bcd(mo));
        bus_write(BASE + 5, e_hi[5] | bcd(d));
        bus_write(BASE + 4, e_hi[4] | bcd(dw));
        bus_write(BASE + 3, e_hi[3] | bcd(h));
        bus_write(BASE + 2, e_hi[2] | bcd(mi));
        bus_write(BASE + 1, e_hi[1] | bcd(s));
        bus_write(BASE + 0, e_hi[0] | bcd(c));
        mc = c; my = y; mmo = mo; md = d; mdw = dw; mh = h; mmi = mi; ms = s;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic en;
        logic [7:0] img [8];
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) e_hi[i] = 8'h00;
        e_stop = 0; e_ft = 0; e_sqw = 0;
        mc = 0; my = 0; mmo = 1; md = 1; mdw = 1; mh = 0; mmi = 0; ms = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        check_all("R1 reset");
        chk("R1 sqw", {7'd0, sqw}, 8'h00);

        // R3: bus gating
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = BASE + 1; #2;
        chk("R3 dout_en idle", {7'd0, dout_en}, 8'h00);
        chk("R3 dout idle", dout, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = '0; din = 8'h55; #2;
        chk("R3 no read while writing", {7'd0, dout_en}, 8'h00);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

        // R4 R5 R6: directed calendar edges
        set_time(20, 0, 2, 28, 3, 23, 59, 59);  do_tick(1); check_all("R5 leap feb28");
        set_time(20, 1, 2, 28, 7, 23, 59, 59);  do_tick(1); check_all("R5 nonleap feb28 R6 dow wrap");
        set_time(20, 4, 2, 29, 2, 23, 59, 59);  do_tick(1); check_all("R5 leap feb29");
        set_time(20, 5, 4, 30, 1, 23, 59, 59);  do_tick(1); check_all("R5 apr30");
        set_time(19, 99, 12, 31, 5, 23, 59, 59); do_tick(1); check_all("R6 year wrap century");
        set_time(39, 99, 12, 31, 6, 23, 59, 58); do_tick(1); do_tick(1); check_all("R6 century 39 wrap");
        set_time(20, 10, 6, 15, 4, 12, 58, 59); do_tick(1); check_all("R4 minute carry");

        // R2: out-of-range and disabled writes are ignored (made visible under write hold)
        bus_write(BASE + 0, 8'h80 | bcd(mc));
        bus_write(11'h010, 8'hA5);
        @(negedge clk); addr = BASE + 7; din = 8'h42; ce_n = 1'b1; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        bus_read(11'h010, v, en);
        chk("R2 out of range reads zero", v, 8'h00);
        chk("R2 out of range read enable", {7'd0, en}, 8'h01);
        bus_read(BASE + 7, v, en);
        chk("R3 write with ce_n high ignored", v, bcd(my));
        bus_write(BASE + 0, bcd(mc));
        check_all("R2 bank intact");

        // R8: write hold discards ticks and loads new values
        bus_write(BASE + 0, 8'h80 | bcd(mc));
        for (int i = 0; i < 8; i++) img[i] = exp_byte(i);
        img[0] = 8'h80 | bcd(mc);
        do_tick(0); do_tick(0); do_tick(0);
        check_image("R8 frozen during write hold", img);
        set_time(21, 33, 7, 4, 2, 8, 30, 0);
        check_all("R8 loaded values");
        do_tick(1); check_all("R8 runs after load");

        // R9: read hold snapshot
        bus_write(BASE + 0, 8'h40 | bcd(mc));
        for (int i = 0; i < 8; i++) img[i] = exp_byte(i);
        img[0] = 8'h40 | bcd(mc);
        for (int k = 0; k < 5; k++) do_tick(1);
        check_image("R9 snapshot frozen", img);
        bus_write(BASE + 0, bcd(mc));
        @(negedge clk);
        check_all("R9 resumes with advanced time");

        // R10: storage bits survive ticks
        e_hi[2] = 8'h80; e_hi[3] = 8'hC0; e_hi[5] = 8'h40; e_hi[6] = 8'hA0; e_hi[4] = 8'h28;
        bus_write(BASE + 2, e_hi[2] | bcd(mmi));
        bus_write(BASE + 3, e_hi[3] | bcd(mh));
        bus_write(BASE + 5, e_hi[5] | bcd(md));
        bus_write(BASE + 6, e_hi[6] | bcd(mmo));
        bus_write(BASE + 4, e_hi[4] | bcd(mdw));
        for (int k = 0; k < 65; k++) do_tick(1);
        check_all("R10 storage bits kept");

        // R11: battery flag from the pin
        batt_low = 1'b1;
        bus_write(BASE + 4, e_hi[4] | bcd(mdw));
        bus_read(BASE + 4, v, en);
        chk("R11 batt flag high", v, {1'b1, e_hi[4][6:0] | bcd(mdw)[6:0]});
        batt_low = 1'b0;
        bus_read(BASE + 4, v, en);
        chk("R11 batt flag low", v, e_hi[4] | bcd(mdw));

        // R12: square wave
        e_hi[4] = 8'h68; e_ft = 1;
        bus_write(BASE + 4, e_hi[4] | bcd(mdw));
        do_tick(1); chk("R12 sqw toggle 1", {7'd0, sqw}, {7'd0, e_sqw});
        do_tick(1); chk("R12 sqw toggle 2", {7'd0, sqw}, {7'd0, e_sqw});
        do_tick(1); chk("R12 sqw toggle 3", {7'd0, sqw}, {7'd0, e_sqw});

        // R7: oscillator stop freezes time and the square wave
        e_hi[1] = 8'h80;
        bus_write(BASE + 1, 8'h80 | bcd(ms));
        e_stop = 1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) do_tick(1);
        check_all("R7 stopped time");
        chk("R7 R12 sqw parked when stopped", {7'd0, sqw}, 8'h00);
        e_sqw = 0;
        e_hi[1] = 8'h00; e_stop = 0;
        bus_write(BASE + 1, bcd(ms));
        do_tick(1); check_all("R7 restarted");

        e_hi[4] = 8'h28; e_ft = 0;
        bus_write(BASE + 4, e_hi[4] | bcd(mdw));
        @(negedge clk);
        chk("R12 sqw low when disabled", {7'd0, sqw}, 8'h00);

        // R4 R5 R6: random times, biased toward rollover
        for (int it = 0; it < 30; it++) begin
            int c, y, mo, d, dw, h, mi, s, n;
            c = $urandom % 40; y = $urandom % 100; mo = 1 + $urandom % 12;
            dw = 1 + $urandom % 7;
            if ($urandom % 2) begin
                d = dim(mo, y); h = 23; mi = 59; s = 30 + $urandom % 30;
            end else begin
                d = 1 + $urandom % dim(mo, y); h = $urandom % 24; mi = $urandom % 60; s = $urandom % 60;
            end
            set_time(c, y, mo, d, dw, h, mi, s);
            n = 1 + $urandom % 40;
            for (int k = 0; k < n; k++) do_tick(1);
            check_all("R4 R5 R6 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule